// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block shifts a 32-bit operand by a count taken from a register, in one of three ways: logical left, logical right, or arithmetic right. Beside the shifted word it returns the last bit shifted out as a carry, an extend flag that copies that carry, and negative, zero and overflow flags taken from the result. An execution pipeline uses it for shift instructions whose count comes from a register. Because such a count can be zero, equal to the word width, or larger than the word width, each of those cases has its own carry rule.

Operands come in on a valid/ready stream and results leave on a second one. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. When `REG_OUT` is 1 (the default), the result sits in a single output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle. A result whose `out_ready` is low stays in the register, unchanged, until it is taken. When `REG_OUT` is 0 the block is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A sender must hold its operand stable while `in_valid` is high and `in_ready` is low.

Top module: `shf_unit`

## Requirements
- R1: Only the low 6 bits of `in_count` take part. Higher count bits have no effect, so a count of 65 acts as 1 and a count of 128 acts as 0.
- R2: A count of zero returns the operand unchanged, and the carry equals `in_carry`.
- R3: A logical left shift by n, for n from 1 to 31, returns the operand shifted left with zero fill, and the carry is operand bit (32 − n).
- R4: A logical left shift by exactly 32 returns zero with carry equal to operand bit 0. A logical left shift by 33 to 63 returns zero with a carry of zero.
- R5: A logical right shift by n, for n from 1 to 31, fills with zeros and gives carry equal to operand bit (n − 1). A shift by exactly 32 gives zero with carry equal to bit 31. A shift by 33 to 63 gives zero with a carry of zero.
- R6: An arithmetic right shift by n, for n from 1 to 31, fills with the sign bit and gives carry equal to bit (n − 1). A shift by 32 or more makes every result bit and the carry equal to the operand's bit 31.
- R7: `out_extend` always equals `out_carry`.
- R8: `out_neg` is result bit 31, `out_zero` is high exactly when the result is zero, and `out_ovf` is always 0.
- R9: `in_kind` is encoded as 0 = logical left, 1 = logical right, 2 = arithmetic right. Code 3 also gives arithmetic right.
- R10: With `REG_OUT` = 1, an operand accepted on one edge shows its result on `out_valid` from the next edge on. `in_ready` equals (!out_valid || out_ready). A result held by a low `out_ready` keeps its value.
- R11: While `rst_n` is low and straight after it rises, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_value | input | 32 | Word to shift |
| in_count | input | 8 | Shift count; only the low 6 bits are used |
| in_kind | input | 2 | Shift kind (R9 encoding) |
| in_carry | input | 1 | Previous carry, passed through on a zero count |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | Last bit shifted out |
| out_extend | output | 1 | Extend flag, equal to the carry |
| out_neg | output | 1 | Result sign |
| out_zero | output | 1 | Result is zero |
| out_ovf | output | 1 | Overflow flag, constant 0 |

## Verification
The assertions assume that an operand offered with `in_valid` high does not change before it is accepted. The checker records the operand on the accepting edge and compares it with the result on the next cycle. `in_kind` and `in_count` may take any value, because every code has a defined meaning. The stimulus raises `in_valid` only when it has an operand ready and keeps all operand fields unchanged until the handshake completes. Back-pressure is applied by dropping `out_ready` at random, and each stall is checked for a stable result.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SK_LSL  = 2'd0,
    SK_LSR  = 2'd1,
    SK_ASR  = 2'd2,
    SK_ASR2 = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic ext;
  } shf_flags_t;
endpackage

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] val,
  input  logic [CNT_W-1:0]  cnt,
  input  shift_kind_e       kind,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  // One guard bit on the shifted-out side catches the carry for every count.
  logic [DATA_W:0] lsl_t, lsr_t, asr_t;

  always_comb begin
    lsl_t = {1'b0, val} << cnt;
    lsr_t = {val, 1'b0} >> cnt;
    asr_t = $unsigned($signed({val, 1'b0}) >>> cnt);
  end

  always_comb begin
    if (cnt == '0) begin
      res  = val;
      cout = cin;
    end else begin
      case (kind)
        SK_LSL: begin
          res  = lsl_t[DATA_W-1:0];
          cout = lsl_t[DATA_W];
        end
        SK_LSR: begin
          res  = lsr_t[DATA_W:1];
          cout = lsr_t[0];
        end
        default: begin
          res  = asr_t[DATA_W:1];
          cout = asr_t[0];
        end
      endcase
    end
  end
endmodule

// File: rtl/shf_flags.sv
module shf_flags
  import shf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  output shf_flags_t        flags
);
  always_comb begin
    flags.neg  = res[DATA_W-1];
    flags.zero = (res == '0);
    flags.ovf  = 1'b0;
    flags.ext  = cout;
  end
endmodule

// File: rtl/shf_outreg.sv
module shf_outreg #(
  parameter int PAY_W   = 33,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  generate
    if (REG_OUT) begin : g_reg
      logic             full_q;
      logic [PAY_W-1:0] pay_q;

      assign in_ready  = !full_q || out_ready;
      assign out_valid = full_q;
      assign out_pay   = pay_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          pay_q  <= '0;
        end else if (in_ready) begin
          full_q <= in_valid;
          if (in_valid) pay_q <= in_pay;
        end
      end
    end else begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_pay   = in_pay;
    end
  endgenerate
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_value,
  input  logic [CNT_IN_W-1:0] in_count,
  input  logic [1:0]          in_kind,
  input  logic                in_carry,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_result,
  output logic                out_carry,
  output logic                out_extend,
  output logic                out_neg,
  output logic                out_zero,
  output logic                out_ovf
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam int PAY_W = DATA_W + 1;

  logic [CNT_W-1:0]  cnt_eff;
  logic [DATA_W-1:0] core_res;
  logic              core_cout;
  logic [PAY_W-1:0]  pay_out;
  shf_flags_t        flg;

  // Count is taken modulo 2*DATA_W.
  assign cnt_eff = in_count[CNT_W-1:0];

  generate
    if (CNT_IN_W > CNT_W) begin : g_cnt_hi
      logic unused_cnt_hi;
      assign unused_cnt_hi = ^in_count[CNT_IN_W-1:CNT_W];
    end
  endgenerate

  shf_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .val  (in_value),
    .cnt  (cnt_eff),
    .kind (shift_kind_e'(in_kind)),
    .cin  (in_carry),
    .res  (core_res),
    .cout (core_cout)
  );

  shf_outreg #(.PAY_W(PAY_W), .REG_OUT(REG_OUT)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pay    ({core_res, core_cout}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pay   (pay_out)
  );

  assign out_result = pay_out[PAY_W-1:1];
  assign out_carry  = pay_out[0];

  shf_flags #(.DATA_W(DATA_W)) u_flags (
    .res   (out_result),
    .cout  (out_carry),
    .flags (flg)
  );

  assign out_neg    = flg.neg;
  assign out_zero   = flg.zero;
  assign out_ovf    = flg.ovf;
  assign out_extend = flg.ext;
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8,
  parameter bit REG_OUT  = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [DATA_W-1:0]   in_value,
  input logic [CNT_IN_W-1:0] in_count,
  input logic [1:0]          in_kind,
  input logic                in_carry,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_result,
  input logic                out_carry,
  input logic                out_extend,
  input logic                out_neg,
  input logic                out_zero,
  input logic                out_ovf
);
  localparam int CNT_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] sh_val;
  logic [CNT_W-1:0]  sh_cnt;
  logic [1:0]        sh_kind;
  logic              sh_cin;

  generate
    if (REG_OUT) begin : g_shadow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_val  <= '0;
          sh_cnt  <= '0;
          sh_kind <= '0;
          sh_cin  <= 1'b0;
        end else if (in_valid && in_ready) begin
          sh_val  <= in_value;
          sh_cnt  <= in_count[CNT_W-1:0];
          sh_kind <= in_kind;
          sh_cin  <= in_carry;
        end
      end

      // R10
      ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));

      // R10
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_carry)));

      // R10
      accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    end else begin : g_direct
      assign sh_val  = in_value;
      assign sh_cnt  = in_count[CNT_W-1:0];
      assign sh_kind = in_kind;
      assign sh_cin  = in_carry;
    end
  endgenerate

  // R2
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh_cnt == '0) |-> (out_result == sh_val && out_carry == sh_cin));

  // R4
  lsl_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh_kind == 2'd0 && sh_cnt > CNT_W'(DATA_W)) |-> (out_result == '0 && !out_carry));

  // R5
  lsr_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh_kind == 2'd1 && sh_cnt > CNT_W'(DATA_W)) |-> (out_result == '0 && !out_carry));

  // R6
  asr_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sh_kind[1] && sh_cnt >= CNT_W'(DATA_W)) |->
      (out_result == {DATA_W{sh_val[DATA_W-1]}} && out_carry == sh_val[DATA_W-1]));

  // R7
  extend_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_extend == out_carry);

  // R8
  flag_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_neg == out_result[DATA_W-1] && out_zero == (out_result == '0) && !out_ovf));
endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_value   (in_value),
  .in_count   (in_count),
  .in_kind    (in_kind),
  .in_carry   (in_carry),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_carry  (out_carry),
  .out_extend (out_extend),
  .out_neg    (out_neg),
  .out_zero   (out_zero),
  .out_ovf    (out_ovf)
);

// File: tb/shf_unit_test.sv
module shf_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_ITEMS    = 400;
  localparam int N_DIR      = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_value = '0;
  logic [7:0]  in_count = '0;
  logic [1:0]  in_kind = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_carry, out_extend, out_neg, out_zero, out_ovf;

  shf_unit uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_count(in_count), .in_kind(in_kind), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_carry(out_carry), .out_extend(out_extend),
    .out_neg(out_neg), .out_zero(out_zero), .out_ovf(out_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] q_res[$];
  logic        q_cy[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bit-at-a-time reference: one step per count unit, carry = bit leaving.
  task automatic model(input logic [31:0] v, input logic [7:0] c8, input logic [1:0] k,
                       input logic ci, output logic [31:0] r, output logic co);
    int n;
    n = int'(c8) % 64;
    r = v;
    co = ci;
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin co = r[31]; r = r << 1; end
        2'd1: begin co = r[0];  r = r >> 1; end
        default: begin co = r[0]; r = {r[31], r[31:1]}; end
      endcase
    end
  endtask

  function automatic string tag_of(input logic [7:0] c8, input logic [1:0] k);
    int c;
    c = int'(c8[5:0]);
    if (c8[7:6] != 2'b00) return "R1";
    if (c == 0) return "R2";
    if (k == 2'd3) return "R9";
    if (k == 2'd0) return (c < 32) ? "R3" : "R4";
    if (k == 2'd1) return "R5";
    return "R6";
  endfunction

  task automatic gen(input int idx, output logic [31:0] v, output logic [7:0] c,
                     output logic [1:0] k, output logic ci);
    ci = 1'b0;
    case (idx)
      0:  begin v = 32'h8000_0001; c = 8'd0;   k = 2'd0; ci = 1'b1; end
      1:  begin v = 32'h8000_0001; c = 8'd0;   k = 2'd1; end
      2:  begin v = 32'h8000_0001; c = 8'd1;   k = 2'd0; end
      3:  begin v = 32'h4000_0000; c = 8'd2;   k = 2'd0; end
      4:  begin v = 32'h0000_0001; c = 8'd31;  k = 2'd0; end
      5:  begin v = 32'h0000_0001; c = 8'd32;  k = 2'd0; end
      6:  begin v = 32'hFFFF_FFFF; c = 8'd33;  k = 2'd0; ci = 1'b1; end
      7:  begin v = 32'hFFFF_FFFF; c = 8'd63;  k = 2'd0; end
      8:  begin v = 32'h0000_0003; c = 8'd1;   k = 2'd1; end
      9:  begin v = 32'h8000_0000; c = 8'd31;  k = 2'd1; end
      10: begin v = 32'h8000_0000; c = 8'd32;  k = 2'd1; end
      11: begin v = 32'hFFFF_FFFF; c = 8'd40;  k = 2'd1; ci = 1'b1; end
      12: begin v = 32'h8000_0000; c = 8'd4;   k = 2'd2; end
      13: begin v = 32'h8000_000F; c = 8'd32;  k = 2'd2; end
      14: begin v = 32'h7FFF_FFFF; c = 8'd50;  k = 2'd2; ci = 1'b1; end
      15: begin v = 32'h8000_0000; c = 8'd63;  k = 2'd2; end
      16: begin v = 32'h0000_0001; c = 8'd65;  k = 2'd0; end
      17: begin v = 32'h1234_5678; c = 8'h80;  k = 2'd1; ci = 1'b1; end
      18: begin v = 32'hF000_0000; c = 8'hC4;  k = 2'd3; end
      19: begin v = 32'h8000_0000; c = 8'd1;   k = 2'd3; end
      20: begin v = 32'h0000_0000; c = 8'd5;   k = 2'd0; end
      default: begin
        v  = $urandom;
        c  = 8'($urandom);
        k  = 2'($urandom);
        ci = 1'($urandom);
      end
    endcase
  endtask

  initial begin
    int issued;
    bit have;
    bit prev_stall;
    logic [31:0] prev_res;
    logic        prev_cy;
    logic [31:0] er;
    logic        ec;
    issued = 0;
    have = 1'b0;
    prev_stall = 1'b0;
    prev_res = '0;
    prev_cy = 1'b0;

    repeat (3) @(negedge clk);
    // R11
    check(out_valid == 1'b0, "R11 valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    check(out_valid == 1'b0, "R11 valid after reset", 32'(out_valid), 32'd0);

    while (issued < N_ITEMS || q_res.size() > 0) begin
      @(negedge clk);
      out_ready = (issued < N_DIR) ? 1'b1 : (($urandom % 4) != 0);
      if (!have && issued < N_ITEMS && (issued < N_DIR || ($urandom % 8) != 0)) begin
        gen(issued, in_value, in_count, in_kind, in_carry);
        have = 1'b1;
      end
      in_valid = have;
      #1;
      // R10 ready rule
      check(in_ready == (!out_valid || out_ready), "R10 ready", 32'(in_ready),
            32'(!out_valid || out_ready));
      if (prev_stall) begin
        // R10 stall hold
        check(out_valid && out_result == prev_res && out_carry == prev_cy,
              "R10 stall", out_result, prev_res);
      end
      prev_stall = out_valid && !out_ready;
      prev_res = out_result;
      prev_cy = out_carry;
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R10 unexpected output", 32'(out_valid), 32'd0);
        end else begin
          er = q_res.pop_front();
          ec = q_cy.pop_front();
          begin
            string t;
            t = q_tag.pop_front();
            check(out_result == er, {t, " result"}, out_result, er);
            check(out_carry == ec, {t, " carry"}, 32'(out_carry), 32'(ec));
          end
          // R7
          check(out_extend == ec, "R7 extend", 32'(out_extend), 32'(ec));
          // R8
          check(out_neg == er[31] && out_zero == (er == 0) && out_ovf == 1'b0, "R8 flags",
                {29'd0, out_neg, out_zero, out_ovf}, {29'd0, er[31], (er == 0), 1'b0});
        end
      end
      if (in_valid && in_ready) begin
        model(in_value, in_count, in_kind, in_carry, er, ec);
        q_res.push_back(er);
        q_cy.push_back(ec);
        q_tag.push_back(tag_of(in_count, in_kind));
        issued++;
        have = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    // R10: nothing left in flight once the queue has drained
    check(!(out_valid && out_ready), "R10 drained", 32'(out_valid), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule